// File: doc/BRIEF.md
# Two-Stage Guest Page Walker

This block turns a 32-bit guest linear address into a host physical address when the guest runs its own two-level paging and each guest-physical address must go through a second translation stage. Each request carries the linear address, the guest root pointer (the page-directory base, which is a guest-physical address) and a flag that says whether guest paging is on. The walker then issues requests on two ports. It sends guest-physical addresses to an external second-stage translator. It reads page-structure entries from memory at the host addresses that the translator returns. When it finishes, it reports a host physical address, a guest page fault or a second-stage violation.

With guest paging on, one walk makes three translations and two reads. The directory entry address is translated and then read. The table entry address is translated and then read. The final page address is translated last. With guest paging off, the linear address is used directly as the guest-physical address, and one translation gives the result. Only one walk is in progress at a time.

Top module: `gla_two_stage_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and no port request or result is active. A request is taken only at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the walk ends, and `req_valid` is ignored during that time.
- R2: With `req_pg_en`=0, exactly one translation request is made, with `sl_req_gpa` equal to the linear address. No memory read is issued. The result address is the translator's returned address.
- R3: With `req_pg_en`=1, the first translation request has `sl_req_gpa` = {root[31:12], lin[31:22], 2'b00}. The directory entry is then read at the host address that the translator returned.
- R4: The second translation request has `sl_req_gpa` = {dir_entry[31:12], lin[21:12], 2'b00}. The table entry is then read at the host address that the translator returned.
- R5: The third translation request has `sl_req_gpa` = {tbl_entry[31:12], lin[11:0]}. On a walk without a fault, `done_hpa` equals the address that the translator returned for this request. Translations and reads never overlap.
- R6: A directory or table entry whose bit 0 (present) is 0 ends the walk with `done_gpf`=1. No further translation or read request is made.
- R7: A translator response with `sl_rsp_fault`=1 ends the walk with `done_slv`=1, at whichever of the three steps it arrives.
- R8: `done_valid` is high for exactly one cycle, the cycle after the final response. `done_gpf` and `done_slv` are never both 1. `req_ready` returns to 1 in the next cycle.
- R9: `sl_req_valid` and `mem_rd_valid` stay high, with a stable address, until the matching `sl_rsp_valid` or `mem_rd_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_lin | input | 32 | Guest linear address |
| req_root | input | 32 | Guest page-directory base (guest-physical) |
| req_pg_en | input | 1 | Guest paging enabled |
| sl_req_valid | output | 1 | Second-stage translation request |
| sl_req_gpa | output | 32 | Guest-physical address to translate |
| sl_rsp_valid | input | 1 | Translator response |
| sl_rsp_hpa | input | 32 | Translated host physical address |
| sl_rsp_fault | input | 1 | Translator reports a violation |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Host address of the entry |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | Walk result valid (one cycle) |
| done_hpa | output | 32 | Host physical result |
| done_gpf | output | 1 | Walk ended with a guest page fault |
| done_slv | output | 1 | Walk ended with a second-stage violation |

## Verification
A request is sampled at a clock edge, and the first port request appears just after that edge. Each later port request appears just after the edge at which the previous response was sampled. `done_valid` appears just after the edge that samples the final response, and `req_ready` returns one cycle later. The bench drives every response at a falling edge and holds it through exactly one rising edge. It samples every output at the falling edge that follows, so each check lands in the cycle where the result is due. Response delays of zero to two cycles check that requests stay held.

// File: rtl/walk_pkg.sv
// Shared types for the two-stage guest page walker.
// Assumes: one walk in progress at a time; the state order has no meaning.
package walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_XL,
        ST_DIR_RD,
        ST_TBL_XL,
        ST_TBL_RD,
        ST_PG_XL,
        ST_DONE
    } walk_st_e;

endpackage

// File: rtl/walk_seq.sv
// Walk sequencer: steps through the translate/read phases of one walk
// and records how the walk ended.
// Assumes: responses are sampled only in the state that waits for them.
module walk_seq
    import walk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     pg_en,
    input  logic     xl_ack,
    input  logic     xl_fault,
    input  logic     rd_ack,
    input  logic     ent_present,
    output walk_st_e st,
    output logic     gpf_q,
    output logic     slv_q
);

    walk_st_e st_nx;

    // Next-state choice for the walk phases.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:   if (req_valid) st_nx = pg_en ? ST_DIR_XL : ST_PG_XL;
            ST_DIR_XL: if (xl_ack) st_nx = xl_fault ? ST_DONE : ST_DIR_RD;
            ST_DIR_RD: if (rd_ack) st_nx = ent_present ? ST_TBL_XL : ST_DONE;
            ST_TBL_XL: if (xl_ack) st_nx = xl_fault ? ST_DONE : ST_TBL_RD;
            ST_TBL_RD: if (rd_ack) st_nx = ent_present ? ST_PG_XL : ST_DONE;
            ST_PG_XL:  if (xl_ack) st_nx = ST_DONE;
            ST_DONE:   st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Fault flags: cleared when a walk starts, set by the step that fails.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpf_q <= 1'b0;
            slv_q <= 1'b0;
        end else if (st == ST_IDLE && req_valid) begin
            gpf_q <= 1'b0;
            slv_q <= 1'b0;
        end else begin
            if ((st == ST_DIR_RD || st == ST_TBL_RD) && rd_ack && !ent_present)
                gpf_q <= 1'b1;
            if ((st == ST_DIR_XL || st == ST_TBL_XL || st == ST_PG_XL) && xl_ack && xl_fault)
                slv_q <= 1'b1;
        end
    end

    // R1: a taken request leaves idle at once.
    a_r1_leave_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req_valid) |=> (st != ST_IDLE));

    // R8: the result cycle is always followed by idle.
    a_r8_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |=> (st == ST_IDLE));

endmodule

// File: rtl/walk_path.sv
// Walk datapath: holds the request, the last entry frame and the last
// translated address, and builds the guest-physical address for each step.
// Assumes: ADDR_W = OFF_W + 2*IDX_W and OFF_W > IDX_W (entries wider than one byte).
module walk_path
    import walk_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int ADDR_W = OFF_W + 2 * IDX_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  walk_st_e                st,
    input  logic                    req_take,
    input  logic [ADDR_W-1:0]       req_lin,
    input  logic [ADDR_W-OFF_W-1:0] req_root_frm,
    input  logic                    req_pg_en,
    input  logic                    xl_ack,
    input  logic [ADDR_W-1:0]       xl_hpa,
    input  logic                    rd_ack,
    input  logic [ADDR_W-OFF_W-1:0] rd_frm,
    output logic [ADDR_W-1:0]       xl_gpa,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic [ADDR_W-1:0]       res_hpa
);

    localparam int FRM_W  = ADDR_W - OFF_W;
    localparam int ENT_SH = OFF_W - IDX_W;

    logic [ADDR_W-1:0] lin_q;
    logic [FRM_W-1:0]  root_q;
    logic [FRM_W-1:0]  ent_q;
    logic [ADDR_W-1:0] hpa_q;
    logic              pg_q;

    logic [IDX_W-1:0]  dir_idx;
    logic [IDX_W-1:0]  tbl_idx;
    logic [OFF_W-1:0]  pg_off;

    assign dir_idx = lin_q[ADDR_W-1 -: IDX_W];
    assign tbl_idx = lin_q[OFF_W +: IDX_W];
    assign pg_off  = lin_q[OFF_W-1:0];

    // Capture the request when a walk starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q  <= '0;
            root_q <= '0;
            pg_q   <= 1'b0;
        end else if (req_take) begin
            lin_q  <= req_lin;
            root_q <= req_root_frm;
            pg_q   <= req_pg_en;
        end
    end

    // Keep the latest translated address and the latest entry frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpa_q <= '0;
            ent_q <= '0;
        end else begin
            if (xl_ack && (st == ST_DIR_XL || st == ST_TBL_XL || st == ST_PG_XL))
                hpa_q <= xl_hpa;
            if (rd_ack && (st == ST_DIR_RD || st == ST_TBL_RD))
                ent_q <= rd_frm;
        end
    end

    // Guest-physical address sent to the translator in each step.
    always_comb begin
        case (st)
            ST_DIR_XL: xl_gpa = {root_q, dir_idx, {ENT_SH{1'b0}}};
            ST_TBL_XL: xl_gpa = {ent_q, tbl_idx, {ENT_SH{1'b0}}};
            ST_PG_XL:  xl_gpa = pg_q ? {ent_q, pg_off} : lin_q;
            default:   xl_gpa = '0;
        endcase
    end

    assign rd_addr = hpa_q;
    assign res_hpa = hpa_q;

    // R1: the captured request does not change while a walk is running.
    a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && $past(st) != ST_IDLE) |-> ($stable(lin_q) && $stable(root_q)));

endmodule

// File: rtl/gla_two_stage_walker.sv
// Two-stage guest page walker top. It translates a guest linear address
// through guest two-level paging, and sends every guest-physical address
// (entry addresses and the final page address) through an external
// second-stage translator.
// Assumes: translator and memory respond in the same cycle or later, and
// a response is only given while the matching request is high.
module gla_two_stage_walker
    import walk_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_lin,
    input  logic [31:0] req_root,
    input  logic        req_pg_en,
    output logic        sl_req_valid,
    output logic [31:0] sl_req_gpa,
    input  logic        sl_rsp_valid,
    input  logic [31:0] sl_rsp_hpa,
    input  logic        sl_rsp_fault,
    output logic        mem_rd_valid,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_ack,
    input  logic [31:0] mem_rd_data,
    output logic        done_valid,
    output logic [31:0] done_hpa,
    output logic        done_gpf,
    output logic        done_slv
);

    localparam int ADDR_W = OFF_W + 2 * IDX_W;

    walk_st_e st;
    logic     gpf_q;
    logic     slv_q;
    logic     req_take;
    logic     unused_bits;

    assign unused_bits = ^{mem_rd_data[OFF_W-1:1], req_root[OFF_W-1:0]};

    assign req_ready    = (st == ST_IDLE);
    assign req_take     = req_valid && req_ready;
    assign sl_req_valid = (st == ST_DIR_XL) || (st == ST_TBL_XL) || (st == ST_PG_XL);
    assign mem_rd_valid = (st == ST_DIR_RD) || (st == ST_TBL_RD);
    assign done_valid   = (st == ST_DONE);
    assign done_gpf     = gpf_q;
    assign done_slv     = slv_q;

    walk_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .pg_en       (req_pg_en),
        .xl_ack      (sl_rsp_valid),
        .xl_fault    (sl_rsp_fault),
        .rd_ack      (mem_rd_ack),
        .ent_present (mem_rd_data[0]),
        .st          (st),
        .gpf_q       (gpf_q),
        .slv_q       (slv_q)
    );

    walk_path #(
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W),
        .ADDR_W (ADDR_W)
    ) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .st           (st),
        .req_take     (req_take),
        .req_lin      (req_lin),
        .req_root_frm (req_root[ADDR_W-1:OFF_W]),
        .req_pg_en    (req_pg_en),
        .xl_ack       (sl_rsp_valid),
        .xl_hpa       (sl_rsp_hpa),
        .rd_ack       (mem_rd_ack),
        .rd_frm       (mem_rd_data[ADDR_W-1:OFF_W]),
        .xl_gpa       (sl_req_gpa),
        .rd_addr      (mem_rd_addr),
        .res_hpa      (done_hpa)
    );

    // R9: a read request is held with a stable address until acknowledged.
    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R9: a translation request is held with a stable address until answered.
    a_r9_xl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_req_valid && !sl_rsp_valid) |=> (sl_req_valid && $stable(sl_req_gpa)));

    // R5: translation and read requests never overlap.
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sl_req_valid && mem_rd_valid));

    // R8: the two fault outcomes exclude each other.
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !(done_gpf && done_slv));

    // R6: a guest fault follows a read that returned a non-present entry.
    a_r6_gpf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_gpf) |-> $past(mem_rd_valid && mem_rd_ack && !mem_rd_data[0]));

    // R7: a violation follows a faulting translator response.
    a_r7_slv_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_slv) |-> $past(sl_req_valid && sl_rsp_valid && sl_rsp_fault));

    // R5: a clean result equals the last translator response.
    a_r5_hpa_src: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_gpf && !done_slv) |-> (done_hpa == $past(sl_rsp_hpa)));

endmodule

// File: tb/sim_gla_two_stage_walker.sv
`timescale 1ns/1ps
module sim_gla_two_stage_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic [31:0] req_root = '0;
    logic        req_pg_en = 1'b0;
    logic        sl_req_valid;
    logic [31:0] sl_req_gpa;
    logic        sl_rsp_valid = 1'b0;
    logic [31:0] sl_rsp_hpa = '0;
    logic        sl_rsp_fault = 1'b0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done_valid;
    logic [31:0] done_hpa;
    logic        done_gpf;
    logic        done_slv;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gla_two_stage_walker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_root(req_root), .req_pg_en(req_pg_en),
        .sl_req_valid(sl_req_valid), .sl_req_gpa(sl_req_gpa),
        .sl_rsp_valid(sl_rsp_valid), .sl_rsp_hpa(sl_rsp_hpa), .sl_rsp_fault(sl_rsp_fault),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .done_valid(done_valid), .done_hpa(done_hpa),
        .done_gpf(done_gpf), .done_slv(done_slv)
    );

    // Translator mapping and memory contents used by the bench models.
    function automatic logic [31:0] host_of(input logic [31:0] g);
        return {g[31:12] ^ 20'h5A5A5, g[11:0]};
    endfunction

    function automatic logic [31:0] entry_at(input logic [31:0] h, input bit p);
        return {h[21:2] ^ 20'h9C3A5, 11'h0, p};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Serve one translation request; checks address, ordering and holding.
    task automatic serve_xl(input logic [31:0] g, input bit flt, input int dly,
                            input string rq, output logic [31:0] h);
        int n = 0;
        bit bad_order = 0;
        while (!sl_req_valid && n < 40) begin
            if (mem_rd_valid) bad_order = 1;
            @(negedge clk);
            n++;
        end
        chk(sl_req_valid && !mem_rd_valid && !bad_order, {rq, " xl request"},
            {31'b0, sl_req_valid}, 32'h1);
        chk(sl_req_gpa == g, {rq, " xl gpa"}, sl_req_gpa, g);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(sl_req_valid && sl_req_gpa == g, "R9 xl held", sl_req_gpa, g);
        end
        h = host_of(g);
        sl_rsp_valid = 1'b1;
        sl_rsp_hpa = h;
        sl_rsp_fault = flt;
        @(posedge clk);
        @(negedge clk);
        sl_rsp_valid = 1'b0;
        sl_rsp_fault = 1'b0;
    endtask

    // Serve one entry read; checks the host address and holding.
    task automatic serve_rd(input logic [31:0] a, input bit p, input int dly,
                            input string rq, output logic [31:0] d);
        int n = 0;
        while (!mem_rd_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(mem_rd_valid && !sl_req_valid, {rq, " read request"}, {31'b0, mem_rd_valid}, 32'h1);
        chk(mem_rd_addr == a, {rq, " read addr"}, mem_rd_addr, a);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(mem_rd_valid && mem_rd_addr == a, "R9 read held", mem_rd_addr, a);
        end
        d = entry_at(a, p);
        mem_rd_ack = 1'b1;
        mem_rd_data = d;
        @(posedge clk);
        @(negedge clk);
        mem_rd_ack = 1'b0;
        mem_rd_data = '0;
    endtask

    // One walk. mode: 0 clean, 1 directory not present, 2 table not present,
    // 3/4/5 translator fault at step 1/2/3 (3 = the only step when paging is off).
    task automatic run_walk(input logic [31:0] lin, input logic [31:0] root, input bit pg,
                            input int mode, input int dly, input bit noise);
        logic [31:0] h, d, pde, pte, exp_hpa;
        bit exp_gpf = 0, exp_slv = 0;
        chk(req_ready, "R1 ready before walk", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1; req_lin = lin; req_root = root; req_pg_en = pg;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R1 busy after accept", {31'b0, req_ready}, 32'h0);
        if (noise) begin
            req_valid = 1'b1; req_lin = ~lin; req_root = ~root; req_pg_en = ~pg;
        end
        exp_hpa = '0;
        if (!pg) begin
            serve_xl(lin, mode == 3, dly, "R2", h);
            exp_slv = (mode == 3);
            exp_hpa = h;
        end else begin
            serve_xl({root[31:12], lin[31:22], 2'b00}, mode == 3, dly, "R3", h);
            if (mode == 3) exp_slv = 1;
            else begin
                serve_rd(h, mode != 1, dly, "R3", d);
                pde = d;
                if (mode == 1) exp_gpf = 1;
                else begin
                    serve_xl({pde[31:12], lin[21:12], 2'b00}, mode == 4, dly, "R4", h);
                    if (mode == 4) exp_slv = 1;
                    else begin
                        serve_rd(h, mode != 2, dly, "R4", d);
                        pte = d;
                        if (mode == 2) exp_gpf = 1;
                        else begin
                            serve_xl({pte[31:12], lin[11:0]}, mode == 5, dly, "R5", h);
                            exp_slv = (mode == 5);
                            exp_hpa = h;
                        end
                    end
                end
            end
        end
        req_valid = 1'b0;
        chk(done_valid, "R8 done pulse", {31'b0, done_valid}, 32'h1);
        chk(done_gpf == exp_gpf, "R6 gpf flag", {31'b0, done_gpf}, {31'b0, exp_gpf});
        chk(done_slv == exp_slv, "R7 slv flag", {31'b0, done_slv}, {31'b0, exp_slv});
        if (!exp_gpf && !exp_slv)
            chk(done_hpa == exp_hpa, pg ? "R5 result hpa" : "R2 result hpa", done_hpa, exp_hpa);
        chk(!sl_req_valid && !mem_rd_valid, "R6 no request after end",
            {30'b0, sl_req_valid, mem_rd_valid}, 32'h0);
        @(negedge clk);
        chk(!done_valid && req_ready, "R8 back to idle",
            {30'b0, done_valid, req_ready}, 32'h1);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !sl_req_valid && !mem_rd_valid && !done_valid, "R1 reset state",
            {28'b0, req_ready, sl_req_valid, mem_rd_valid, done_valid}, 32'h8);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] lin;
            logic [31:0] root;
            lin  = (i * 32'h0C4F_3A17) ^ {i[3:0], 28'h0} ^ 32'h0040_1FFF * i[0];
            root = {(i * 20'h3B1C9) ^ 20'hF0F0F, 12'(i * 12'h155)};
            for (int m = 0; m < 6; m++)
                run_walk(lin, root, 1'b1, m, (i + m) % 3, (i % 4) == 1);
            run_walk(lin, root, 1'b0, 0, i % 3, (i % 4) == 2);
            run_walk(lin, root, 1'b0, 3, (i + 1) % 3, 1'b0);
        end
        run_walk(32'hFFFF_FFFF, 32'hFFFF_F000, 1'b1, 0, 0, 1'b0);
        run_walk(32'h0000_0000, 32'h0000_0000, 1'b1, 0, 2, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule